// File: doc/BRIEF.md
# Status Flag Register with Branch Condition Evaluator

This block keeps the arithmetic status flags of a 16-bit processor core: carry, zero, sign, overflow, parity and auxiliary carry. An execution stage hands it a result word together with the carry, overflow and auxiliary-carry outcomes. The block derives zero, sign and parity from that word on its own and stores all six flags on the update strobe.

From the stored flags it answers, in the same cycle, whether a conditional branch selected by a 4-bit code is taken. The codes cover single-flag tests and the unsigned and signed comparisons. A separate select replaces the flag test with a check that the 16-bit count operand is zero.

The flags can also be moved through an 8-bit byte. A load strobe writes five flags from a byte. A save strobe captures a packed image of the flags onto the byte output, where three reserved positions always read as fixed constants.

Top module: `flag_cond_unit`

## Requirements
- R1: After reset all six flags are 0 and `flag_byte` reads 8'h02.
- R2: On `upd_en` without `ld_en`, CF, OF and AF take `upd_cf`, `upd_of` and `upd_af`. ZF becomes 1 exactly when all bits of `upd_result` are 0. SF takes the top bit of `upd_result`. PF becomes 1 when the low 8 bits of `upd_result` hold an even number of ones, and the upper bits play no part in PF. With neither strobe set, the flags hold.
- R3: With `cnt_test`=0, the even codes of `cond_sel` test one flag for set: 0 OF, 2 CF, 4 ZF, 8 SF, 10 PF (parity even).
- R4: Unsigned compound codes: code 6 is taken when CF=1 or ZF=1 (below or equal). Code 7 is taken when CF=0 and ZF=0 (above).
- R5: Signed codes: 12 is taken when SF differs from OF (less). 13 is taken when SF equals OF (greater or equal). 14 is taken when SF differs from OF or ZF=1 (less or equal, also used for not greater). 15 is taken when ZF=0 and SF equals OF (greater).
- R6: Every odd code is the exact inverse of the even code one below it (1 no overflow, 3 no carry / above or equal, 5 not zero, 9 not sign, 11 parity odd).
- R7: With `cnt_test`=1, `taken` is 1 exactly when `count` is zero, whatever `cond_sel` and the flags hold.
- R8: On `ld_en`, `ld_byte` bits 7, 6, 4, 2 and 0 are written to SF, ZF, AF, PF and CF. OF keeps its value, and bits 5, 3 and 1 of `ld_byte` have no effect.
- R9: On `sv_en`, `flag_byte` captures {SF, ZF, 0, AF, 0, PF, 1, CF} (bit 7 down to 0) of the flags held before that edge, and holds that value until the next `sv_en`.
- R10: When `ld_en` and `upd_en` are both set in one cycle, the load alone takes effect and the update is discarded.
- R11: `flag_byte` bits 5 and 3 always read 0 and bit 1 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update flags from an execution result |
| upd_result | input | RESULT_W | Result word used for ZF, SF and PF |
| upd_cf | input | 1 | New carry flag |
| upd_of | input | 1 | New overflow flag |
| upd_af | input | 1 | New auxiliary carry flag |
| ld_en | input | 1 | Load five flags from `ld_byte` |
| ld_byte | input | 8 | Packed flag byte to load |
| sv_en | input | 1 | Capture the packed flags onto `flag_byte` |
| cond_sel | input | 4 | Branch condition code |
| cnt_test | input | 1 | Select the count-is-zero test instead of a flag test |
| count | input | COUNT_W | Count operand for the zero test |
| taken | output | 1 | Branch condition holds |
| flag_byte | output | 8 | Last captured packed flag byte |

## Verification
Two functions can collide in one cycle. A flag-byte load and a result update can arrive on the same edge, and a save can coincide with either of them. The random stimulus sets the three strobes independently, so every overlap occurs many times. Directed cases also force a load and an update with opposite carry and zero values. The outcome is then read back through the branch codes and a later save: the load must have won, OF must be unchanged, and a save on the same edge must show the flags from before it.

// File: rtl/flagcc_pkg.sv
package flagcc_pkg;

  localparam int BYTE_W   = 8;
  localparam int CC_W     = 4;
  localparam int PARITY_W = 8;
  localparam logic [BYTE_W-1:0] SNAP_RESET = 8'b0000_0010;

  typedef struct packed {
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
    logic of;
  } flags_t;

  typedef enum logic [CC_W-2:0] {
    BASE_OVF   = 3'd0,
    BASE_CARRY = 3'd1,
    BASE_ZERO  = 3'd2,
    BASE_BE    = 3'd3,
    BASE_SIGN  = 3'd4,
    BASE_PAR   = 3'd5,
    BASE_LT    = 3'd6,
    BASE_LE    = 3'd7
  } base_e;

  function automatic logic even_ones(input logic [PARITY_W-1:0] v);
    return ~^v;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_flags(input flags_t f);
    return {f.sf, f.zf, 1'b0, f.af, 1'b0, f.pf, 1'b1, f.cf};
  endfunction

  function automatic logic base_test(input base_e b, input logic cf,
                                     input logic zf, input logic sf,
                                     input logic of, input logic pf);
    case (b)
      BASE_OVF:   return of;
      BASE_CARRY: return cf;
      BASE_ZERO:  return zf;
      BASE_BE:    return cf | zf;
      BASE_SIGN:  return sf;
      BASE_PAR:   return pf;
      BASE_LT:    return sf ^ of;
      default:    return (sf ^ of) | zf;
    endcase
  endfunction

endpackage

// File: rtl/flag_regs.sv
module flag_regs
  import flagcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en,
  input  logic   ld_en,
  input  flags_t upd_flags,
  input  flags_t ld_flags,
  output flags_t flags_q,
  output logic   ld_over_upd
);

  assign ld_over_upd = ld_en & upd_en;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags_q <= '0;
    else if (ld_en)
      flags_q <= ld_flags;
    else if (upd_en)
      flags_q <= upd_flags;
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flagcc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               cf,
  input  logic               zf,
  input  logic               sf,
  input  logic               of,
  input  logic               pf,
  input  logic [CC_W-1:0]    cond_sel,
  input  logic               cnt_test,
  input  logic [COUNT_W-1:0] count,
  output logic               taken
);

  logic base_hit;
  logic flag_hit;
  logic count_is_zero;

  always_comb begin
    base_hit      = base_test(base_e'(cond_sel[CC_W-1:1]), cf, zf, sf, of, pf);
    flag_hit      = base_hit ^ cond_sel[0];
    count_is_zero = (count == '0);
    taken         = cnt_test ? count_is_zero : flag_hit;
  end

endmodule

// File: rtl/snap_reg.sv
module snap_reg
  import flagcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sv_en,
  input  logic [BYTE_W-1:0] packed_now,
  output logic [BYTE_W-1:0] flag_byte
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_byte <= SNAP_RESET;
    else if (sv_en)
      flag_byte <= packed_now;
  end

endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flagcc_pkg::*;
#(
  parameter int RESULT_W = 16,
  parameter int COUNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [RESULT_W-1:0] upd_result,
  input  logic                upd_cf,
  input  logic                upd_of,
  input  logic                upd_af,
  input  logic                ld_en,
  input  logic [BYTE_W-1:0]   ld_byte,
  input  logic                sv_en,
  input  logic [CC_W-1:0]     cond_sel,
  input  logic                cnt_test,
  input  logic [COUNT_W-1:0]  count,
  output logic                taken,
  output logic [BYTE_W-1:0]   flag_byte
);

  localparam int SIGN_BIT = RESULT_W - 1;

  flags_t              flags_q;
  flags_t              upd_flags;
  flags_t              ld_flags;
  logic                ld_over_upd;
  logic [BYTE_W-1:0]   packed_now;

  // Result-derived flags: zero over the full word, parity over the low byte.
  always_comb begin
    upd_flags.cf = upd_cf;
    upd_flags.of = upd_of;
    upd_flags.af = upd_af;
    upd_flags.zf = (upd_result == '0);
    upd_flags.sf = upd_result[SIGN_BIT];
    upd_flags.pf = even_ones(upd_result[PARITY_W-1:0]);
  end

  // Byte load: reserved positions are not decoded, OF is carried over.
  always_comb begin
    ld_flags.sf = ld_byte[7];
    ld_flags.zf = ld_byte[6];
    ld_flags.af = ld_byte[4];
    ld_flags.pf = ld_byte[2];
    ld_flags.cf = ld_byte[0];
    ld_flags.of = flags_q.of;
  end

  flag_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .ld_en      (ld_en),
    .upd_flags  (upd_flags),
    .ld_flags   (ld_flags),
    .flags_q    (flags_q),
    .ld_over_upd(ld_over_upd)
  );

  cond_eval #(.COUNT_W(COUNT_W)) i_eval (
    .cf      (flags_q.cf),
    .zf      (flags_q.zf),
    .sf      (flags_q.sf),
    .of      (flags_q.of),
    .pf      (flags_q.pf),
    .cond_sel(cond_sel),
    .cnt_test(cnt_test),
    .count   (count),
    .taken   (taken)
  );

  assign packed_now = pack_flags(flags_q);

  snap_reg i_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sv_en     (sv_en),
    .packed_now(packed_now),
    .flag_byte (flag_byte)
  );

endmodule

// File: rtl/flag_cond_chk.sv
module flag_cond_chk
  import flagcc_pkg::*;
#(
  parameter int RESULT_W = 16,
  parameter int COUNT_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_en,
  input logic [RESULT_W-1:0] upd_result,
  input logic                upd_cf,
  input logic                upd_of,
  input logic                upd_af,
  input logic                ld_en,
  input logic [BYTE_W-1:0]   ld_byte,
  input logic                sv_en,
  input logic [CC_W-1:0]     cond_sel,
  input logic                cnt_test,
  input logic [COUNT_W-1:0]  count,
  input logic                taken,
  input logic [BYTE_W-1:0]   flag_byte,
  input flags_t              flags_q,
  input logic                ld_over_upd
);

  AST_UPD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ld_en) |=> (flags_q.cf == $past(upd_cf) && flags_q.of == $past(upd_of) && flags_q.af == $past(upd_af))); // R2
  AST_UPD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ld_en) |=> (flags_q.zf == ($past(upd_result) == '0))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !ld_en) |=> $stable(flags_q)); // R2
  AST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_test && cond_sel == 4'd7) |-> (taken == (!flags_q.cf && !flags_q.zf))); // R4
  AST_GREATER: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_test && cond_sel == 4'd15) |-> (taken == (!flags_q.zf && (flags_q.sf == flags_q.of)))); // R5
  AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_test |-> (taken == (count == '0))); // R7
  AST_LOAD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (((pack_flags(flags_q) ^ $past(ld_byte)) & 8'hD5) == 8'h00)); // R8
  AST_LOAD_KEEPS_OF: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (flags_q.of == $past(flags_q.of))); // R8
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sv_en |=> (flag_byte == pack_flags($past(flags_q)))); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sv_en |=> $stable(flag_byte)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_over_upd |=> (flags_q.cf == $past(ld_byte[0]) && flags_q.zf == $past(ld_byte[6]))); // R10
  AST_RESERVED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_byte[5] == 1'b0 && flag_byte[3] == 1'b0 && flag_byte[1] == 1'b1)); // R11

endmodule

bind flag_cond_unit flag_cond_chk #(.RESULT_W(RESULT_W), .COUNT_W(COUNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en     (upd_en),
  .upd_result (upd_result),
  .upd_cf     (upd_cf),
  .upd_of     (upd_of),
  .upd_af     (upd_af),
  .ld_en      (ld_en),
  .ld_byte    (ld_byte),
  .sv_en      (sv_en),
  .cond_sel   (cond_sel),
  .cnt_test   (cnt_test),
  .count      (count),
  .taken      (taken),
  .flag_byte  (flag_byte),
  .flags_q    (flags_q),
  .ld_over_upd(ld_over_upd)
);

// File: tb/test_flag_cond_unit.sv
module test_flag_cond_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [15:0] upd_result = '0;
  logic        upd_cf = 1'b0;
  logic        upd_of = 1'b0;
  logic        upd_af = 1'b0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_byte = '0;
  logic        sv_en = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        cnt_test = 1'b0;
  logic [15:0] count = 16'h0001;
  logic        taken;
  logic [7:0]  flag_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the flags and of the saved byte
  bit m_cf, m_zf, m_sf, m_of, m_pf, m_af;
  logic [7:0] m_snap = 8'h02;

  always #10 clk = ~clk;

  flag_cond_unit i_flag_cond_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_result(upd_result),
    .upd_cf(upd_cf), .upd_of(upd_of), .upd_af(upd_af), .ld_en(ld_en),
    .ld_byte(ld_byte), .sv_en(sv_en), .cond_sel(cond_sel), .cnt_test(cnt_test),
    .count(count), .taken(taken), .flag_byte(flag_byte)
  );

  function automatic bit ref_even(input logic [7:0] v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    return (ones % 2) == 0;
  endfunction

  function automatic bit ref_taken(input logic [3:0] cc, input bit ct, input logic [15:0] cnt);
    if (ct) return cnt == 16'd0;
    case (cc)
      4'd0:  return m_of;
      4'd1:  return !m_of;
      4'd2:  return m_cf;
      4'd3:  return !m_cf;
      4'd4:  return m_zf;
      4'd5:  return !m_zf;
      4'd6:  return m_cf || m_zf;
      4'd7:  return !m_cf && !m_zf;
      4'd8:  return m_sf;
      4'd9:  return !m_sf;
      4'd10: return m_pf;
      4'd11: return !m_pf;
      4'd12: return m_sf != m_of;
      4'd13: return m_sf == m_of;
      4'd14: return (m_sf != m_of) || m_zf;
      default: return !m_zf && (m_sf == m_of);
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] cc, input bit ct);
    if (ct) return "R7";
    if (cc == 4'd6 || cc == 4'd7) return "R4";
    if (cc >= 4'd12) return "R5";
    if (cc[0]) return "R6";
    return "R3";
  endfunction

  function automatic logic [7:0] ref_byte();
    return {m_sf, m_zf, 1'b0, m_af, 1'b0, m_pf, 1'b1, m_cf};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after a falling edge, check taken, model the rising edge, check flag_byte.
  task automatic step(input bit u, input bit l, input bit s, input bit ct,
                      input logic [3:0] cc, input logic [15:0] cnt,
                      input logic [7:0] b, input logic [15:0] res,
                      input bit c, input bit o, input bit a);
    upd_en = u; ld_en = l; sv_en = s; cnt_test = ct; cond_sel = cc; count = cnt;
    ld_byte = b; upd_result = res; upd_cf = c; upd_of = o; upd_af = a;
    #2;
    check(tag_of(cc, ct), {15'd0, taken}, {15'd0, ref_taken(cc, ct, cnt)});
    @(posedge clk);
    if (s) m_snap = ref_byte();
    if (l) begin
      m_sf = b[7]; m_zf = b[6]; m_af = b[4]; m_pf = b[2]; m_cf = b[0];
    end else if (u) begin
      m_cf = c; m_of = o; m_af = a;
      m_zf = (res == 16'd0); m_sf = res[15]; m_pf = ref_even(res[7:0]);
    end
    #2;
    check("R9", {8'd0, flag_byte}, {8'd0, m_snap});
    check("R11", {8'd0, flag_byte & 8'h2A}, 16'h0002);
    @(negedge clk);
  endtask

  task automatic idle_test(input logic [3:0] cc, input bit ct, input logic [15:0] cnt);
    step(0, 0, 0, ct, cc, cnt, 8'h00, 16'h0000, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1", {8'd0, flag_byte}, 16'h0002);
    cond_sel = 4'd4; #1; check("R1", {15'd0, taken}, 16'd0);
    cond_sel = 4'd5; #1; check("R1", {15'd0, taken}, 16'd1);
    @(negedge clk);

    // R8: load all ones, OF must stay 0, reserved positions forced
    step(0, 1, 0, 0, 4'd0, 16'd1, 8'hFF, 16'h0, 0, 0, 0);
    step(0, 0, 1, 0, 4'd0, 16'd1, 8'h00, 16'h0, 0, 0, 0);
    check("R8", {8'd0, flag_byte}, 16'h00D7);
    idle_test(4'd0, 0, 16'd1);
    check("R8", {15'd0, taken}, 16'd0);
    // R8: load zeros with reserved bits set
    step(0, 1, 0, 0, 4'd4, 16'd1, 8'h2A, 16'h0, 0, 0, 0);
    step(0, 0, 1, 0, 4'd4, 16'd1, 8'h00, 16'h0, 0, 0, 0);
    check("R8", {8'd0, flag_byte}, 16'h0002);

    // R2: upper bits do not disturb PF; SF from MSB; ZF over the whole word
    step(1, 0, 0, 0, 4'd0, 16'd1, 8'h00, 16'hFF00, 0, 1, 0);
    idle_test(4'd10, 0, 16'd1);
    check("R2", {15'd0, taken}, 16'd1);
    idle_test(4'd4, 0, 16'd1);
    check("R2", {15'd0, taken}, 16'd0);
    idle_test(4'd13, 0, 16'd1);
    step(1, 0, 0, 0, 4'd0, 16'd1, 8'h00, 16'h0100, 1, 0, 1);
    idle_test(4'd11, 0, 16'd1);
    check("R2", {15'd0, taken}, 16'd0);

    // R10: load and update together, opposite values
    step(1, 0, 0, 0, 4'd0, 16'd1, 8'h00, 16'h8001, 1, 1, 0);
    step(1, 1, 1, 0, 4'd0, 16'd1, 8'h40, 16'h8001, 1, 0, 1);
    idle_test(4'd2, 0, 16'd1);
    check("R10", {15'd0, taken}, 16'd0);
    idle_test(4'd4, 0, 16'd1);
    check("R10", {15'd0, taken}, 16'd1);
    idle_test(4'd0, 0, 16'd1);
    check("R10", {15'd0, taken}, 16'd1);

    // R7: count zero overrides a failing flag code
    idle_test(4'd5, 1, 16'h0000);
    check("R7", {15'd0, taken}, 16'd1);
    idle_test(4'd4, 1, 16'h8000);
    check("R7", {15'd0, taken}, 16'd0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] res;
      logic [15:0] cnt;
      bit ct;
      case ($urandom_range(0, 3))
        0: res = 16'h0000;
        1: res = {$urandom_range(0, 255), 8'h00};
        default: res = 16'($urandom);
      endcase
      cnt = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      ct = ($urandom_range(0, 7) == 0);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, ct, 4'($urandom), cnt,
           8'($urandom), res, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule